// File: doc/BRIEF.md
# Reprogram Request and Startup Sequencer

This block supervises the restart of a programmable device. It watches a shared open-drain status line that signals "configured" when high and carries a restart request when pulled low. It can only pull that line low or let it go. While the device runs, a low level on the line counts as a restart request only if it holds across two ticks of a slow internal timer. Short disturbances are therefore ignored.

Once a request is accepted, the block turns off the user output buffers and pulls the status line low itself. It then runs a configuration-memory clear of fixed length and raises an initialized flag. It waits for the external loader to report that loading is complete, and then starts operation. A static option sets the order of two events: the status line is released either one clock before the user outputs turn on, or one clock after. Operation starts on completion even if another device still holds the shared line low. A fresh request needs the line to go high and then low again.

Top module: `reprog_sequencer`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `done_pull_low`=1, `user_oe`=0, `clear_active`=1 and `init_done`=0. Leaving reset starts a clear phase.
- R2: The timer ticks at the clock edges whose index k since reset release (first edge with reset high is k=0) satisfies k mod TICK_DIV = TICK_DIV-1. During operation a request is accepted only when `done_line` is sampled low at two consecutive ticks and at every edge between them. A low level that covers fewer than two ticks leaves `user_oe`=1.
- R3: An accepted request takes effect at the edge of the second low tick. From the next cycle on, `user_oe`=0, `clear_active`=1 and `done_pull_low`=1.
- R4: The clear phase lasts exactly CLEAR_TICKS*TICK_DIV cycles. After it, `clear_active`=0 and `init_done`=1.
- R5: `done_pull_low` stays 1 throughout the clear phase and while waiting for `load_complete`.
- R6: `load_complete` sampled high while `init_done`=1 starts the startup sequence. Outside that phase it has no effect: in operation, `user_oe` stays 1 and `done_pull_low` stays 0.
- R7: With `done_first`=1, the cycle after `load_complete` is taken has `done_pull_low`=0 and `user_oe`=0. The cycle after that has `user_oe`=1.
- R8: With `done_first`=0, the cycle after `load_complete` is taken has `user_oe`=1 and `done_pull_low`=1. The cycle after that has `done_pull_low`=0.
- R9: Operation starts even if `done_line` is held low from outside. A line that is already low on entry to operation never produces a request.
- R10: A request needs the line to be seen high during operation before the low period. A high-then-low sequence that covers two ticks after startup is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_line | input | 1 | Sampled level of the wired-AND status line (already synchronous to clk) |
| load_complete | input | 1 | Loader reports configuration data fully loaded |
| done_first | input | 1 | Static option: 1 releases the line before outputs turn on, 0 after |
| done_pull_low | output | 1 | 1 pulls the status line low, 0 releases it |
| user_oe | output | 1 | Enable for all user output buffers |
| clear_active | output | 1 | Configuration-memory clear in progress |
| init_done | output | 1 | Clear finished, waiting for loading |

## Verification
All outputs decode the state register, so each result shows up one clock after the edge that samples its cause. The bench drives inputs on falling edges and checks on the next falling edge. The bench keeps its own count of edges since reset release, which gives it the tick edges. From that count it works out, for each low pulse, how many ticks the pulse covers and therefore whether a request is due. It also predicts the exact edge at which the request takes effect and the edge, CLEAR_TICKS*TICK_DIV later, at which `init_done` rises, and samples one cycle before and one cycle after each of those edges. The two release orders are checked on the first and second cycles after `load_complete` is taken.

// File: rtl/rps_pkg.sv
// Shared types for the reprogram/startup sequencer.
package rps_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,   // memory clear, line pulled low, outputs off
        ST_WAIT  = 2'd1,   // initialized, waiting for loader
        ST_STEP  = 2'd2,   // one-cycle gap between line release and output enable
        ST_RUN   = 2'd3    // normal operation
    } rps_state_e;
endpackage

// File: rtl/rps_tick_gen.sv
// Slow timer: one-cycle tick every TICK_DIV clocks, free running from reset.
// Assumes: TICK_DIV >= 1. The first tick comes TICK_DIV-1 edges after reset release.
module rps_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Divider counter, wraps at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (TICK_DIV > 1)) |=> !tick);  // R2
endmodule

// File: rtl/rps_req_filter.sv
// Restart request filter: during operation, flags a request when the line
// is low at two consecutive ticks with no high sample between them.
// Assumes: line_high is synchronous to clk. enable is high only in operation.
// The filter is re-armed only by a high sample seen while enabled.
module rps_req_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic line_high,
    output logic req
);
    logic armed;
    logic low_seen;

    // Track arming and the first low tick; clear everything outside operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            armed    <= 1'b0;
            low_seen <= 1'b0;
        end else if (line_high) begin
            armed    <= 1'b1;
            low_seen <= 1'b0;
        end else if (tick && armed) begin
            low_seen <= 1'b1;
        end
    end

    assign req = enable && armed && !line_high && tick && low_seen;

    AST_REQ_LOW_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !$past(line_high));  // R2
    AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(enable));  // R10
endmodule

// File: rtl/reprog_sequencer.sv
// Reprogram request and startup sequencer (top).
// Filters restart requests on the open-drain status line, runs a timed clear,
// waits for loading, then releases the line and enables outputs in the
// order chosen by done_first.
// Assumes: done_line already synchronous to clk; done_first static while
// the sequence runs.
module reprog_sequencer #(
    parameter int TICK_DIV    = 4,
    parameter int CLEAR_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_line,
    input  logic load_complete,
    input  logic done_first,
    output logic done_pull_low,
    output logic user_oe,
    output logic clear_active,
    output logic init_done
);
    import rps_pkg::*;

    localparam int CCW = (CLEAR_TICKS > 1) ? $clog2(CLEAR_TICKS) : 1;
    localparam logic [CCW-1:0] CLR_LAST = CCW'(CLEAR_TICKS - 1);

    rps_state_e     state;
    logic [CCW-1:0] clr_cnt;
    logic           tick;
    logic           req;
    logic           in_run;

    rps_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign in_run = (state == ST_RUN);

    rps_req_filter u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (in_run),
        .line_high (done_line),
        .req       (req)
    );

    // Phase sequencing and clear-length counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_cnt <= '0;
        end else begin
            case (state)
                ST_CLEAR: if (tick) begin
                    if (clr_cnt == CLR_LAST) begin
                        state   <= ST_WAIT;
                        clr_cnt <= '0;
                    end else begin
                        clr_cnt <= clr_cnt + 1'b1;
                    end
                end
                ST_WAIT:  if (load_complete) state <= ST_STEP;
                ST_STEP:  state <= ST_RUN;
                default:  if (req) begin
                    state   <= ST_CLEAR;
                    clr_cnt <= '0;
                end
            endcase
        end
    end

    // Output decode from the phase and the release-order option.
    always_comb begin
        clear_active  = (state == ST_CLEAR);
        init_done     = (state == ST_WAIT);
        user_oe       = (state == ST_RUN) || ((state == ST_STEP) && !done_first);
        done_pull_low = (state == ST_CLEAR) || (state == ST_WAIT) ||
                        ((state == ST_STEP) && !done_first);
    end

    AST_OE_OFF_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_active |-> !user_oe);  // R3
    AST_HOLD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_active || init_done) |-> done_pull_low);  // R5
    AST_INIT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(clear_active));  // R4
    AST_LOAD_LEAVES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && load_complete) |=> !init_done);  // R6
    AST_RELEASE_THEN_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(done_pull_low) && !user_oe) |=> user_oe);  // R7
    AST_OE_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(user_oe) && done_pull_low) |=> !done_pull_low);  // R8
endmodule

// File: tb/reprog_sequencer_tb.sv
module reprog_sequencer_tb;
    localparam int TD = 4;
    localparam int CT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic load_complete = 1'b0;
    logic done_first = 1'b0;
    logic done_line;
    logic done_pull_low, user_oe, clear_active, init_done;

    int cyc = 0;
    int wd = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    // Wired-AND line: low if the block or an outside device pulls it.
    assign done_line = !(done_pull_low || ext_low);

    reprog_sequencer #(.TICK_DIV(TD), .CLEAR_TICKS(CT)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .done_line     (done_line),
        .load_complete (load_complete),
        .done_first    (done_first),
        .done_pull_low (done_pull_low),
        .user_oe       (user_oe),
        .clear_active  (clear_active),
        .init_done     (init_done)
    );

    // Edge index since reset release; at a falling edge it names the next rising edge.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nstep(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ticks_in(input int start, input int len);
        int n = 0;
        for (int j = 0; j < len; j++)
            if (((start + j) % TD) == TD - 1) n++;
        return n;
    endfunction

    task automatic align_tick();
        while ((cyc % TD) != TD - 1) @(negedge clk);
    endtask

    // Wait for the initialized phase, hand over loading, check the release order.
    task automatic boot(input logic mode);
        int g = 0;
        while (!init_done && g < 1000) begin @(negedge clk); g++; end
        chk(init_done, 1, "R4 init reached");
        chk(done_pull_low, 1, "R5 held low while waiting");
        done_first = mode;
        load_complete = 1'b1;
        nstep(1);
        load_complete = 1'b0;
        if (mode) begin
            chk(done_pull_low, 0, "R7 released first");
            chk(user_oe, 0, "R7 outputs still off");
        end else begin
            chk(user_oe, 1, "R8 outputs first");
            chk(done_pull_low, 1, "R8 still pulled low");
        end
        nstep(1);
        chk(user_oe, 1, mode ? "R7 outputs on" : "R8 outputs on");
        chk(done_pull_low, 0, mode ? "R7 line released" : "R8 line released");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        nstep(2);
        chk(done_pull_low, 1, "R1 pull low in reset");
        chk(user_oe, 0, "R1 outputs off in reset");
        chk(clear_active, 1, "R1 clear in reset");
        chk(init_done, 0, "R1 init low in reset");
        rst_n = 1'b1;
        nstep(1);
        chk(clear_active, 1, "R1 clear after reset");
        // R4: init_done rises after exactly CT*TD edges from reset release.
        while (cyc < CT * TD - 1) @(negedge clk);
        chk(init_done, 0, "R4 init not early");
        chk(done_pull_low, 1, "R5 low in clear");
        nstep(1);
        chk(init_done, 1, "R4 init on time");
        chk(clear_active, 0, "R4 clear ended");
        boot(1'b0);

        // R2: a low pulse covering one tick is ignored.
        nstep(3);
        align_tick();
        ext_low = 1'b1;
        nstep(TD);
        ext_low = 1'b0;
        chk(user_oe, 1, "R2 single tick ignored");
        nstep(1);
        chk(user_oe, 1, "R2 still running");

        // R3/R4: two-tick low, exact request edge and clear length.
        nstep(2);
        align_tick();
        ext_low = 1'b1;
        nstep(TD);
        chk(user_oe, 1, "R3 not before second tick");
        nstep(1);
        chk(user_oe, 0, "R3 outputs off");
        chk(clear_active, 1, "R3 clear started");
        chk(done_pull_low, 1, "R3 pulls line low");
        ext_low = 1'b0;
        nstep(CT * TD - 1);
        chk(init_done, 0, "R4 init not early after request");
        nstep(1);
        chk(init_done, 1, "R4 init on time after request");
        boot(1'b1);

        // R6: loader flag in operation has no effect.
        load_complete = 1'b1;
        nstep(3);
        chk(user_oe, 1, "R6 oe unaffected");
        chk(done_pull_low, 0, "R6 line unaffected");
        load_complete = 1'b0;

        // R9: outside device holds the line low through the restart.
        nstep(2);
        ext_low = 1'b1;
        nstep(2 * TD + 1);
        chk(clear_active, 1, "R9 request taken");
        boot(1'b0);
        nstep(3 * TD);
        chk(user_oe, 1, "R9 runs with line held low");
        chk(clear_active, 0, "R9 no request from held low");

        // R10: high then low again is accepted.
        ext_low = 1'b0;
        nstep(1);
        ext_low = 1'b1;
        nstep(2 * TD + 1);
        chk(user_oe, 0, "R10 rearmed request");
        ext_low = 1'b0;
        boot(1'b1);

        // R2: random pulses against the tick-count prediction.
        for (int it = 0; it < 40; it++) begin
            int s, len, n;
            nstep(2 + int'($urandom % 5));
            s = cyc;
            len = 1 + int'($urandom % (3 * TD));
            n = ticks_in(s, len);
            ext_low = 1'b1;
            nstep(len);
            ext_low = 1'b0;
            chk(user_oe, (n < 2) ? 1 : 0, "R2 random pulse");
            if (n >= 2) boot(logic'($urandom % 2));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule